// File: doc/BRIEF.md
# Interrupt Descriptor Table Lookup

This block turns an 8-bit interrupt vector into the 8-byte interrupt descriptor that belongs to it. Software first programs a 48-bit table register through a write port: the low 16 bits hold the table limit, which is the offset of the table's last valid byte, and the upper 32 bits hold the physical base address. After that, a requester presents a vector on a valid/ready handshake. The block places the entry at base + vector*8 and checks that the whole 8-byte entry lies at or below the limit. It then fetches the entry through a 32-bit memory read port and returns the 64-bit descriptor.

There are two faults. A lookup made before the table register has ever been written returns a not-initialised fault. A lookup whose entry would extend past the limit returns a limit fault. This happens even though the vector itself is always below 256, so a short table rejects the high vectors. Neither fault issues a memory read. The block does not interpret the descriptor contents.

The memory port carries one read at a time. `mem_req_o` is a one-cycle pulse with `mem_addr_o`. The memory answers with `mem_rvalid_i` and `mem_rdata_i` at least one cycle after the pulse.

Top module: `idt_lookup`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `mem_req_o`, `desc_valid_o` and `fault_o` are 0.
- R2: A write with `tbl_we_i` high loads the limit from `tbl_wdata_i[15:0]` and the base from `tbl_wdata_i[47:16]`. Every lookup accepted after that write uses the new values.
- R3: A lookup accepted before any table write gives `fault_o` = 1 with `fault_code_o` = 2'b01 in the cycle after acceptance, and no memory read is issued for it.
- R4: A lookup with vector*8 + 7 greater than the limit gives `fault_o` = 1 with `fault_code_o` = 2'b10 in the cycle after acceptance, and no memory read is issued for it.
- R5: An in-range lookup issues exactly two reads. The first is at base + vector*8, and the second is at that address + 4, both modulo 2^32.
- R6: `desc_o` returns {second read data, first read data}. `desc_valid_o` pulses for one cycle, in the cycle after the second `mem_rvalid_i`.
- R7: A request is accepted only while `req_ready_o` is 1. `req_ready_o` is 0 from the cycle after an in-range acceptance until the cycle in which `desc_valid_o` is 1, and requests held during that time cause no reads.
- R8: `mem_req_o` is a one-cycle pulse, and no new read is issued while an earlier one is still unanswered.
- R9: `fault_o` and `desc_valid_o` are never 1 together. `fault_o` is 1 only in the cycle after an accepted request, and it is 0 in the next cycle unless another request was accepted.
- R10: A vector whose last descriptor byte lies exactly at the limit (vector*8 + 7 = limit) is in range and fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table register write strobe |
| tbl_wdata_i | input | 48 | {base[31:0], limit[15:0]} |
| req_valid_i | input | 1 | Vector request valid |
| req_vector_i | input | 8 | Interrupt vector |
| req_ready_o | output | 1 | Block idle, request can be taken |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| desc_valid_o | output | 1 | Descriptor valid pulse |
| desc_o | output | 64 | Fetched descriptor |
| fault_o | output | 1 | Lookup fault pulse |
| fault_code_o | output | 2 | 01 not initialised, 10 past limit |

## Verification
The hardest cases to reach are the ones at the limit edge: an entry whose last byte falls exactly on the limit, and the entry just past it. With random limits these are rare, so the stimulus adds directed vectors on both sides of a chosen limit. It also draws limits small enough that a good share of random vectors fall past the table. Requests held high through a busy fetch, random memory latency, and a base near the top of the address space exercise the ready hold-off and the address wrap.

// File: rtl/idt_lookup_pkg.sv
package idt_lookup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE_LO, ST_WAIT_LO, ST_ISSUE_HI, ST_WAIT_HI
  } fetch_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_NOINIT = 2'b01,
    FLT_LIMIT  = 2'b10
  } fault_e;
endpackage

// File: rtl/idt_table_reg.sv
module idt_table_reg #(
  parameter int BASE_W  = 32,
  parameter int LIMIT_W = 16,
  localparam int TBL_W  = BASE_W + LIMIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [TBL_W-1:0]   wdata_i,
  output logic [BASE_W-1:0]  base_o,
  output logic [LIMIT_W-1:0] limit_o,
  output logic               valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      limit_o <= '0;
      valid_o <= 1'b0;
    end else if (we_i) begin
      limit_o <= wdata_i[LIMIT_W-1:0];
      base_o  <= wdata_i[TBL_W-1:LIMIT_W];
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/idt_range_check.sv
module idt_range_check #(
  parameter int VEC_W       = 8,
  parameter int BASE_W      = 32,
  parameter int LIMIT_W     = 16,
  parameter int ENTRY_BYTES = 8,
  localparam int SHIFT      = $clog2(ENTRY_BYTES),
  localparam int OFF_W      = VEC_W + SHIFT,
  localparam int CMP_W      = ((OFF_W > LIMIT_W) ? OFF_W : LIMIT_W) + 1
) (
  input  logic [VEC_W-1:0]   vector_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [BASE_W-1:0]  addr_o,
  output logic               in_range_o
);
  logic [CMP_W-1:0] offset;
  logic [CMP_W-1:0] last_byte;

  always_comb begin
    offset     = CMP_W'(vector_i) << SHIFT;
    last_byte  = offset + CMP_W'(ENTRY_BYTES - 1);
    in_range_o = (last_byte <= CMP_W'(limit_i));
    addr_o     = base_i + BASE_W'(offset);
  end
endmodule

// File: rtl/idt_fetch_ctrl.sv
module idt_fetch_ctrl
  import idt_lookup_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  localparam int DESC_W = 2 * WORD_W,
  localparam int STEP   = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              table_valid_i,
  input  logic              in_range_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              desc_valid_o,
  output logic [DESC_W-1:0] desc_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o
);
  fetch_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] lo_q;
  fault_e            code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      lo_q         <= '0;
      desc_o       <= '0;
      desc_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      code_q       <= FLT_NONE;
    end else begin
      desc_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      code_q       <= FLT_NONE;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (!table_valid_i) begin
              fault_o <= 1'b1;
              code_q  <= FLT_NOINIT;
            end else if (!in_range_i) begin
              fault_o <= 1'b1;
              code_q  <= FLT_LIMIT;
            end else begin
              addr_q  <= addr_i;
              state_q <= ST_ISSUE_LO;
            end
          end
        end
        ST_ISSUE_LO: state_q <= ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (mem_rvalid_i) begin
            lo_q    <= mem_rdata_i;
            state_q <= ST_ISSUE_HI;
          end
        end
        ST_ISSUE_HI: state_q <= ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (mem_rvalid_i) begin
            desc_o       <= {mem_rdata_i, lo_q};
            desc_valid_o <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_ISSUE_LO) || (state_q == ST_ISSUE_HI);
  assign mem_addr_o   = addr_q + ((state_q == ST_ISSUE_HI) ? ADDR_W'(STEP) : '0);
  assign fault_code_o = code_q;
endmodule

// File: rtl/idt_lookup.sv
module idt_lookup #(
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 16,
  parameter int WORD_W  = 32,
  localparam int TBL_W  = ADDR_W + LIMIT_W,
  localparam int DESC_W = 2 * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [TBL_W-1:0]   tbl_wdata_i,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   req_vector_i,
  output logic               req_ready_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               desc_valid_o,
  output logic [DESC_W-1:0]  desc_o,
  output logic               fault_o,
  output logic [1:0]         fault_code_o
);
  logic [ADDR_W-1:0]  tbl_base;
  logic [LIMIT_W-1:0] tbl_limit;
  logic               tbl_valid;
  logic [ADDR_W-1:0]  entry_addr;
  logic               entry_ok;

  idt_table_reg #(.BASE_W(ADDR_W), .LIMIT_W(LIMIT_W)) table_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .wdata_i (tbl_wdata_i),
    .base_o  (tbl_base),
    .limit_o (tbl_limit),
    .valid_o (tbl_valid)
  );

  idt_range_check #(
    .VEC_W(VEC_W), .BASE_W(ADDR_W), .LIMIT_W(LIMIT_W), .ENTRY_BYTES(DESC_W / 8)
  ) range_i (
    .vector_i   (req_vector_i),
    .base_i     (tbl_base),
    .limit_i    (tbl_limit),
    .addr_o     (entry_addr),
    .in_range_o (entry_ok)
  );

  idt_fetch_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .table_valid_i (tbl_valid),
    .in_range_i    (entry_ok),
    .addr_i        (entry_addr),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .desc_valid_o  (desc_valid_o),
    .desc_o        (desc_o),
    .fault_o       (fault_o),
    .fault_code_o  (fault_code_o)
  );
endmodule

// File: rtl/idt_lookup_chk.sv
module idt_lookup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       mem_req_o,
  input logic       mem_rvalid_i,
  input logic       desc_valid_o,
  input logic       fault_o,
  input logic [1:0] fault_code_o
);
  logic outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding <= 1'b0;
    else if (mem_req_o) outstanding <= 1'b1;
    else if (mem_rvalid_i) outstanding <= 1'b0;
  end

  assert_busy_not_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_single_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outstanding);

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_fault_no_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_req_o && !outstanding));

  assert_fault_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o == 2'b01 || fault_code_o == 2'b10));

  assert_fault_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(req_valid_i && req_ready_o));

  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && desc_valid_o));

  assert_desc_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |=> !desc_valid_o);

  assert_desc_after_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> $past(mem_rvalid_i));
endmodule

bind idt_lookup idt_lookup_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .desc_valid_o (desc_valid_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o)
);

// File: tb/idt_lookup_tb_top.sv
`timescale 1ns/1ps
module idt_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [47:0] tbl_wdata = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        desc_valid;
  logic [63:0] desc;
  logic        fault;
  logic [1:0]  fault_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  idt_lookup dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_wdata_i(tbl_wdata),
    .req_valid_i(req_valid), .req_vector_i(req_vector), .req_ready_o(req_ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .desc_valid_o(desc_valid), .desc_o(desc),
    .fault_o(fault), .fault_code_o(fault_code)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // memory responder with random latency
  int          cyc = 0;
  int          mem_count = 0;
  logic [31:0] addr_log [2];
  int          last_rv_cyc = 0;
  bit          pend = 0;
  int          dly = 0;
  logic [31:0] paddr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rvalid  <= 1'b1;
        mem_rdata   <= mem_word(paddr);
        last_rv_cyc <= cyc;
        pend        <= 0;
      end else dly <= dly - 1;
    end
    if (rst_n && mem_req) begin
      pend  <= 1;
      paddr <= mem_addr;
      dly   <= int'($urandom % 3);
      if (mem_count < 2) addr_log[mem_count] <= mem_addr;
      mem_count <= mem_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [31:0] tb_base = '0;
  logic [15:0] tb_limit = '0;
  bit          tb_init = 0;

  task automatic tbl_write(input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tbl_we = 1'b1;
    tbl_wdata = {b, l};
    @(negedge clk);
    tbl_we = 1'b0;
    tb_base = b; tb_limit = l; tb_init = 1;
  endtask

  task automatic lookup(input logic [7:0] vec, input bit hold_busy);
    int          last;
    logic [31:0] ea;
    bit          seen;
    @(negedge clk);
    mem_count = 0;
    chk(req_ready == 1'b1, "R7", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_vector = vec;
    @(negedge clk);
    last = int'(vec) * 8 + 7;
    ea = tb_base + 32'(int'(vec) * 8);
    if (!tb_init || last > int'(tb_limit)) begin
      req_valid = 1'b0;
      if (!tb_init)
        chk(fault && fault_code == 2'b01, "R3", "uninit fault", {fault, fault_code}, 64'h5);
      else
        chk(fault && fault_code == 2'b10, "R4", "limit fault", {fault, fault_code}, 64'h6);
      chk(!desc_valid, "R9", "no desc with fault", 64'(desc_valid), 64'd0);
      @(negedge clk);
      chk(!fault, "R9", "fault pulse ends", 64'(fault), 64'd0);
      repeat (2) @(negedge clk);
      chk(mem_count == 0, tb_init ? "R4" : "R3", "no read on fault", 64'(mem_count), 64'd0);
    end else begin
      chk(!fault, "R4", "no fault in range", 64'(fault), 64'd0);
      seen = 0;
      for (int n = 0; n < 60; n++) begin
        if (desc_valid) begin seen = 1; break; end
        chk(!req_ready, "R7", "ready low while busy", 64'(req_ready), 64'd0);
        req_vector = 8'($urandom);
        req_valid = hold_busy;
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(seen, "R6", "desc_valid seen", 64'(seen), 64'd1);
      chk(desc == {mem_word(ea + 32'd4), mem_word(ea)}, "R6", "descriptor value",
          desc, {mem_word(ea + 32'd4), mem_word(ea)});
      chk(cyc == last_rv_cyc + 2, "R6", "valid one cycle after data",
          64'(cyc), 64'(last_rv_cyc + 2));
      chk(req_ready, "R7", "ready with desc_valid", 64'(req_ready), 64'd1);
      chk(mem_count == 2, "R8", "two reads", 64'(mem_count), 64'd2);
      chk(addr_log[0] == ea, "R5", "low word address", 64'(addr_log[0]), 64'(ea));
      chk(addr_log[1] == ea + 32'd4, "R5", "high word address",
          64'(addr_log[1]), 64'(ea + 32'd4));
      @(negedge clk);
      chk(!desc_valid, "R6", "valid is a pulse", 64'(desc_valid), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !desc_valid && !fault, "R1", "reset outputs",
        {req_ready, mem_req, desc_valid, fault}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !desc_valid && !fault, "R1", "after reset release",
        {req_ready, mem_req, desc_valid, fault}, 64'h8);

    lookup(8'd0, 0);                       // R3
    lookup(8'd200, 1);                     // R3

    tbl_write(32'h0000_2000, 16'h00FF);    // R2
    lookup(8'd31, 0);                      // R10: last byte == limit
    lookup(8'd32, 0);                      // R4: first past limit
    lookup(8'd0, 1);
    lookup(8'd255, 0);                     // R4
    tbl_write(32'h0010_0000, 16'hFFFF);    // R2: new table used
    lookup(8'd255, 1);
    lookup(8'd32, 0);
    tbl_write(32'hFFFF_FFFC, 16'h0007);    // R5: address wrap
    lookup(8'd0, 0);
    lookup(8'd1, 0);
    tbl_write(32'h0000_4000, 16'h0006);    // R4: table shorter than one entry
    lookup(8'd0, 0);

    for (int i = 0; i < 150; i++) begin
      if (i % 15 == 0) begin
        logic [15:0] l;
        l = ($urandom % 2 == 0) ? 16'($urandom % 2100) : 16'($urandom);
        tbl_write($urandom, l);
      end
      if (i % 5 == 0 && tb_limit >= 16'd7 && tb_limit < 16'd2047) begin
        lookup(8'((int'(tb_limit) - 7) / 8), 0);   // R10 neighbourhood
        lookup(8'((int'(tb_limit) - 7) / 8 + 1), 1);
      end
      lookup(8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule